// File: doc/BRIEF.md
# Eighth-Root Twiddle Multiplier (Shift-Add)

This block rotates a complex fixed-point sample by one of the two eighth-root twiddles that an FFT butterfly needs most often: W8^1 = (√2/2)(1 − j) or W8^3 = −(√2/2)(1 + j). It uses no hardware multiplier. Both products reduce to the sum a+b and the difference b−a of the real and imaginary parts, each scaled by √2/2 and then routed, with a sign change in one case, to the two outputs.

The scale factor is approximated as 181/256 (0.70703125). The block builds it from three shift-add steps: 5x = x + 4x, then 45x = 5x + 8·5x, then 181x = 4·45x + x. Each step sits in its own pipeline stage. A new sample may enter on every clock. The select bit travels with its data, so each sample may use a different twiddle. The result comes out one bit wider than the input, so no extreme input can overflow.

Top module: `twiddle_w8_cmul`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly 4 clock cycles. The result of a sample accepted at one rising edge is presented after the 4th following edge.
- R2: The scaling is scl(x) = floor(x·181/256), where x is the exact 17-bit signed sum or difference. It is an arithmetic right shift by 8 of 181·x.
- R3: With `in_sel` = 0 (W8^1), `out_re` = scl(a+b) and `out_im` = scl(b−a), where a = `in_re` and b = `in_im`.
- R4: With `in_sel` = 1 (W8^3), `out_re` = scl(b−a) and `out_im` = −scl(a+b).
- R5: While `out_vld` is 0, both data outputs are 0. Data presented with `in_vld` = 0 has no effect on any output.
- R6: For every input, including −32768 and 32767 in either part, each output lies within 6 LSB of the ideal product with √2/2 = 0.70710678. No output exceeds ±46341.
- R7: Samples may arrive on consecutive cycles with a different select each. Each result uses the select that arrived with its own sample.
- R8: While `rst_n` is low, `out_vld`, `out_re` and `out_im` are 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| in_sel | input | 1 | Twiddle select: 0 = W8^1, 1 = W8^3 |
| in_re | input | 16 | Real part a, two's complement |
| in_im | input | 16 | Imaginary part b, two's complement |
| out_vld | output | 1 | Result valid |
| out_re | output | 17 | Real part of result, two's complement |
| out_im | output | 17 | Imaginary part of result, two's complement |

## Verification
The hardest case to reach from the ports is a select that falls out of step with its data. The results stay plausible, so the fault only shows when consecutive samples carry different selects and different values. The random phase therefore drives an unbroken stream with a randomly flipping select and randomly dropped valid cycles. The directed phase covers the full-scale corners (both parts at −32768, opposite extremes, ±1), where the widest sum meets the truncation of a negative product.

// File: rtl/twiddle_w8_cmul.sv
module twiddle_w8_cmul #(
  parameter int IN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld,
  input  logic                   in_sel,
  input  logic signed [IN_W-1:0] in_re,
  input  logic signed [IN_W-1:0] in_im,
  output logic                   out_vld,
  output logic signed [IN_W:0]   out_re,
  output logic signed [IN_W:0]   out_im
);
  localparam int SW   = IN_W + 1;
  localparam int P5W  = SW + 3;
  localparam int P45W = SW + 6;
  localparam int PW   = SW + 8;
  localparam int FRAC = 8;
  localparam int DEPTH = 4;

  logic signed [SW-1:0] a_ext, b_ext;
  logic signed [SW-1:0] lane_in [2];
  logic signed [SW-1:0] scaled  [2];
  logic [DEPTH-2:0] vld_q, sel_q;

  assign a_ext = {in_re[IN_W-1], in_re};
  assign b_ext = {in_im[IN_W-1], in_im};
  assign lane_in[0] = a_ext + b_ext;
  assign lane_in[1] = b_ext - a_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      sel_q <= '0;
    end else begin
      vld_q <= {vld_q[DEPTH-3:0], in_vld};
      sel_q <= {sel_q[DEPTH-3:0], in_sel};
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [SW-1:0]   x1, x2, x3;
    logic signed [P5W-1:0]  p5;
    logic signed [P45W-1:0] p45;
    logic signed [PW-1:0]   p181;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x1  <= '0;
        x2  <= '0;
        x3  <= '0;
        p5  <= '0;
        p45 <= '0;
      end else begin
        x1  <= lane_in[g];
        x2  <= x1;
        x3  <= x2;
        p5  <= {{3{x1[SW-1]}}, x1} + {x1[SW-1], x1, 2'b00};
        p45 <= {{3{p5[P5W-1]}}, p5} + {p5, 3'b000};
      end
    end

    assign p181      = {p45, 2'b00} + {{FRAC{x3[SW-1]}}, x3};
    assign scaled[g] = p181[PW-1:FRAC];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_re  <= '0;
      out_im  <= '0;
    end else if (vld_q[DEPTH-2]) begin
      out_vld <= 1'b1;
      if (sel_q[DEPTH-2]) begin
        out_re <= scaled[1];
        out_im <= -scaled[0];
      end else begin
        out_re <= scaled[0];
        out_im <= scaled[1];
      end
    end else begin
      out_vld <= 1'b0;
      out_re  <= '0;
      out_im  <= '0;
    end
  end

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_vld == $past(in_vld, 4)));

  a_r3_equal_parts_w1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && $past(in_vld, 4) && !$past(in_sel, 4) &&
     $past(in_re, 4) == $past(in_im, 4)) |-> (out_im == '0));

  a_r4_equal_parts_w3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && $past(in_vld, 4) && $past(in_sel, 4) &&
     $past(in_re, 4) == $past(in_im, 4)) |-> (out_re == '0));

  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_re == '0 && out_im == '0));

  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_re >= -46341 && out_re <= 46341 &&
                 out_im >= -46341 && out_im <= 46341));
endmodule

// File: tb/sim_twiddle_w8_cmul.sv
module sim_twiddle_w8_cmul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic in_sel = 1'b0;
  logic signed [15:0] in_re = '0;
  logic signed [15:0] in_im = '0;
  logic out_vld;
  logic signed [16:0] out_re, out_im;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic  hv [4];
  logic  hs [4];
  int    ha [4];
  int    hb [4];
  string ht [4];

  always #5 clk = ~clk;

  twiddle_w8_cmul u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sel(in_sel),
    .in_re(in_re), .in_im(in_im),
    .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
  );

  // R2: floor(x*181/256)
  function automatic int scl(int x);
    longint p = longint'(x) * 181;
    return int'(p >>> 8);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_near(string tag, int got, real ideal);
    real e = real'(got) - ideal;
    checks++;
    if (e > 6.0 || e < -6.0) begin
      fails++;
      $display("FAIL %s: got %0d expected %f (+-6)", tag, got, ideal);
    end
  endtask

  task automatic step(logic v, logic s, int a, int b, string tag);
    @(negedge clk);
    chk("R1 valid delay", int'(out_vld), int'(hv[3]));
    if (hv[3]) begin
      int sm = ha[3] + hb[3];
      int df = hb[3] - ha[3];
      int er = hs[3] ? scl(df) : scl(sm);
      int ei = hs[3] ? -scl(sm) : scl(df);
      string rq = hs[3] ? "R4" : "R3";
      chk($sformatf("%s/%s re", ht[3], rq), int'(out_re), er);
      chk($sformatf("%s/%s im", ht[3], rq), int'(out_im), ei);
      if (ht[3] == "R6") begin
        real c = 0.70710678;
        chk_near("R6 accuracy re", int'(out_re), hs[3] ? df * c : sm * c);
        chk_near("R6 accuracy im", int'(out_im), hs[3] ? -sm * c : df * c);
      end
    end else begin
      chk("R5 idle re", int'(out_re), 0);
      chk("R5 idle im", int'(out_im), 0);
    end
    for (int i = 3; i > 0; i--) begin
      hv[i] = hv[i-1]; hs[i] = hs[i-1]; ha[i] = ha[i-1]; hb[i] = hb[i-1]; ht[i] = ht[i-1];
    end
    hv[0] = v; hs[0] = s; ha[0] = a; hb[0] = b; ht[0] = tag;
    in_vld = v;
    in_sel = s;
    in_re  = 16'(a);
    in_im  = 16'(b);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      hv[i] = 1'b0; hs[i] = 1'b0; ha[i] = 0; hb[i] = 0; ht[i] = "";
    end
    void'($urandom(32'd1234));
    // R8: reset holds outputs at zero even with valid input present
    in_vld = 1'b1; in_sel = 1'b1; in_re = 16'sd1000; in_im = -16'sd2000;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R8 reset vld", int'(out_vld), 0);
    chk("R8 reset re", int'(out_re), 0);
    chk("R8 reset im", int'(out_im), 0);
    in_vld = 1'b0;
    rst_n = 1'b1;

    // directed corners, both twiddles (R6 range and accuracy)
    for (int s = 0; s < 2; s++) begin
      step(1'b1, s[0], 0, 0, "R6");
      step(1'b1, s[0], 32767, 32767, "R6");
      step(1'b1, s[0], -32768, -32768, "R6");
      step(1'b1, s[0], 32767, -32768, "R6");
      step(1'b1, s[0], -32768, 32767, "R6");
      step(1'b1, s[0], 1, 0, "R6");
      step(1'b1, s[0], 0, -1, "R6");
      step(1'b1, s[0], -1, -1, "R6");
      step(1'b1, s[0], 12345, -321, "R6");
    end
    // R5: junk data with valid low must not show up
    step(1'b0, 1'b1, -32768, 32767, "R5");
    step(1'b0, 1'b0, 32767, 32767, "R5");
    step(1'b1, 1'b0, 100, 200, "R2");
    step(1'b0, 1'b1, 9999, -9999, "R5");
    // R7: back-to-back stream, select flips randomly, gaps random
    for (int n = 0; n < 600; n++) begin
      logic v = ($urandom % 5) != 0;
      logic s = $urandom % 2;
      int a = int'($signed(16'($urandom)));
      int b = int'($signed(16'($urandom)));
      step(v, s, a, b, "R7");
    end
    // alternating select at full rate
    for (int n = 0; n < 16; n++)
      step(1'b1, n[0], 1000 * n - 8000, 7000 - 900 * n, "R7");
    for (int n = 0; n < 5; n++) step(1'b0, 1'b0, 0, 0, "R5");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule